// File: doc/BRIEF.md
# Multi-Address I2C Slave Address Matcher

This block sits behind the synchronizers of an I2C slave port and watches the SCL and SDA lines. It waits for a START condition and shifts in the first byte that follows. It then compares the 7-bit address part of that byte against three programmable slave addresses. It also recognises the general call address. Each programmed address has its own sticky match flag, and the flags are visible in an 8-bit read-only status word.

When the byte it has just received sets at least one flag, the block acknowledges by pulling SDA low for the ninth SCL clock. Otherwise it leaves SDA released and waits for the next START. Software controls the block through four inputs:

- an enable bit;
- a soft-reset bit;
- a select bit that turns address comparison off when the free-format mode is chosen;
- a strobe that marks a write to the data register.

Any of the clearing conditions empties all flags. These are disable, soft reset and a data-register write.

Top module: `addr_match_top`

## Requirements
- R1: After reset, `statusOut` is 0 and `sdaDriveLow` is 0, so SDA is released.
- R2: A START is SDA falling while SCL is high. The byte after a START is sampled MSB first on SCL rising edges, and its eighth bit is R/W. A new START restarts the byte from its first bit.
- R3: Status bit i (i = 0, 1, 2) becomes 1 when the received 7-bit address equals `slvAddrs[7*i+6 : 7*i]`. The other flags are not changed by that byte.
- R4: A received address of 7'b0000000 with R/W = 0 (general call) sets all three flags.
- R5: Flags are sticky. A later byte that matches nothing leaves them unchanged, and a later match ORs in its own flag.
- R6: When the current byte sets any flag, `sdaDriveLow` is 1 during the ninth SCL high phase and is 0 again after the ninth SCL falling edge. When no flag is set, `sdaDriveLow` stays 0.
- R7: While `freeFormat` is 1, no flag is set and no ACK is driven.
- R8: While `enable` is 0, all flags read 0, and received bytes neither set flags nor get an ACK.
- R9: A cycle with `softReset` = 1 clears all flags.
- R10: A cycle with `dataWrStb` = 1 clears all flags.
- R11: Status bits 7 to 3 always read 0.
- R12: The R/W bit does not affect the comparison against programmed addresses. A matching address with R/W = 1 sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| enable | input | 1 | Interface enable; 0 clears flags and idles the block |
| softReset | input | 1 | Soft reset; 1 clears flags and idles the block |
| freeFormat | input | 1 | 1 disables address comparison |
| dataWrStb | input | 1 | One-cycle strobe for a data-register write; clears flags |
| slvAddrs | input | 21 | Three 7-bit slave addresses, address i at bits 7*i+6 : 7*i |
| statusOut | output | 8 | Match flags in bits 2..0; bits 7..3 are 0 |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain ACK) |

## Verification
The assertions take three things for granted about the inputs:

- SCL and SDA are already synchronized to `clk`.
- Each SCL phase lasts several clock cycles, so the compare cycle after the eighth rising edge never coincides with an SCL falling edge.
- The master changes SDA only while SCL is low, except to form a START.

The stimulus meets these assumptions. It uses a bus model in which every SCL half period spans eight clocks and data moves only in the middle of the low phase. The SDA line is modelled as a wired AND of the master drive and the block's pull-down, so the block's own ACK cannot look like a START.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_EVAL,
    ST_ACKWAIT,
    ST_ACKDRV
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic shiftBit;
    logic evalByte;
    logic clearFlags;
  } dpCmd_t;

endpackage

// File: rtl/addr_match_ctrl.sv
module addr_match_ctrl
  import addr_match_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   enable,
  input  logic   softReset,
  input  logic   dataWrStb,
  input  logic   hitAny,
  output dpCmd_t cmd,
  output logic   sdaDriveLow
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctrlState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt;
  logic sclQ, sdaQ;
  logic active, sclRise, sclFall, startSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign active    = enable & ~softReset;
  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startSeen = sclIn & sclQ & sdaQ & ~sdaIn;

  always_comb begin
    stateNxt = state;
    if (!active) begin
      stateNxt = ST_IDLE;
    end else if (startSeen) begin
      stateNxt = ST_ADDR;
    end else begin
      case (state)
        ST_ADDR:    if (sclRise && bitCnt == LAST_BIT) stateNxt = ST_EVAL;
        ST_EVAL:    stateNxt = hitAny ? ST_ACKWAIT : ST_IDLE;
        ST_ACKWAIT: if (sclFall) stateNxt = ST_ACKDRV;
        ST_ACKDRV:  if (sclFall) stateNxt = ST_IDLE;
        default:    stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (startSeen) begin
        bitCnt <= '0;
      end else if (state == ST_ADDR && sclRise) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    cmd.clearShift = active & startSeen;
    cmd.shiftBit   = active & ~startSeen & (state == ST_ADDR) & sclRise;
    cmd.evalByte   = active & ~startSeen & (state == ST_EVAL);
    cmd.clearFlags = ~active | dataWrStb;
  end

  assign sdaDriveLow = (state == ST_ACKDRV);

endmodule

// File: rtl/addr_match_dp.sv
module addr_match_dp
  import addr_match_pkg::*;
#(
  parameter int NUM_ADDR = 3,
  parameter int ADDR_W   = 7,
  parameter int STAT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dpCmd_t                     cmd,
  input  logic                       sdaIn,
  input  logic                       freeFormat,
  input  logic [NUM_ADDR*ADDR_W-1:0] slvAddrs,
  output logic                       hitAny,
  output logic [STAT_W-1:0]          statusOut
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int RSV_W  = STAT_W - NUM_ADDR;

  logic [BYTE_W-1:0]   shiftReg;
  logic [ADDR_W-1:0]   rxAddr;
  logic                rxRw;
  logic                genCall;
  logic [NUM_ADDR-1:0] hit;
  logic [NUM_ADDR-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (cmd.clearShift) begin
      shiftReg <= '0;
    end else if (cmd.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
    end
  end

  assign rxAddr  = shiftReg[BYTE_W-1:1];
  assign rxRw    = shiftReg[0];
  assign genCall = (rxAddr == '0) & ~rxRw;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
    assign hit[i] = (rxAddr == slvAddrs[i*ADDR_W +: ADDR_W]) | genCall;
  end

  assign hitAny = ~freeFormat & (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (cmd.clearFlags) begin
      flags <= '0;
    end else if (cmd.evalByte && !freeFormat) begin
      flags <= flags | hit;
    end
  end

  assign statusOut = {{RSV_W{1'b0}}, flags};

endmodule

// File: rtl/addr_match_top.sv
module addr_match_top
  import addr_match_pkg::*;
#(
  parameter int NUM_ADDR = 3,
  parameter int ADDR_W   = 7,
  parameter int STAT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic                       enable,
  input  logic                       softReset,
  input  logic                       freeFormat,
  input  logic                       dataWrStb,
  input  logic [NUM_ADDR*ADDR_W-1:0] slvAddrs,
  output logic [STAT_W-1:0]          statusOut,
  output logic                       sdaDriveLow
);

  dpCmd_t cmd;
  logic   hitAny;

  addr_match_ctrl #(.BYTE_W(ADDR_W + 1)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .enable      (enable),
    .softReset   (softReset),
    .dataWrStb   (dataWrStb),
    .hitAny      (hitAny),
    .cmd         (cmd),
    .sdaDriveLow (sdaDriveLow)
  );

  addr_match_dp #(
    .NUM_ADDR (NUM_ADDR),
    .ADDR_W   (ADDR_W),
    .STAT_W   (STAT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .sdaIn      (sdaIn),
    .freeFormat (freeFormat),
    .slvAddrs   (slvAddrs),
    .hitAny     (hitAny),
    .statusOut  (statusOut)
  );

endmodule

// File: rtl/addr_match_chk.sv
module addr_match_chk #(
  parameter int NUM_ADDR = 3,
  parameter int STAT_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic              enable,
  input logic              softReset,
  input logic              freeFormat,
  input logic              dataWrStb,
  input logic [STAT_W-1:0] statusOut,
  input logic              sdaDriveLow
);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    statusOut[STAT_W-1:NUM_ADDR] == '0);

  assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> statusOut[NUM_ADDR-1:0] == '0);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> statusOut[NUM_ADDR-1:0] == '0);

  assert_write_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dataWrStb |=> statusOut[NUM_ADDR-1:0] == '0);

  assert_free_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeFormat |=> (statusOut[NUM_ADDR-1:0] & ~$past(statusOut[NUM_ADDR-1:0])) == '0);

  assert_ack_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaDriveLow) |-> !sclIn);

  assert_idle_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || softReset) |=> !sdaDriveLow);

endmodule

bind addr_match_top addr_match_chk #(.NUM_ADDR(NUM_ADDR), .STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclIn       (sclIn),
  .enable      (enable),
  .softReset   (softReset),
  .freeFormat  (freeFormat),
  .dataWrStb   (dataWrStb),
  .statusOut   (statusOut),
  .sdaDriveLow (sdaDriveLow)
);

// File: tb/tb_addr_match_top.sv
module tb_addr_match_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaLine;
  logic        enable = 1'b1;
  logic        softReset = 1'b0;
  logic        freeFormat = 1'b0;
  logic        dataWrStb = 1'b0;
  logic [20:0] slvAddrs;
  logic [7:0]  statusOut;
  logic        sdaDriveLow;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaLine  = sdaM & ~sdaDriveLow;
  assign slvAddrs = {7'h56, 7'h34, 7'h12};

  addr_match_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (scl),
    .sdaIn       (sdaLine),
    .enable      (enable),
    .softReset   (softReset),
    .freeFormat  (freeFormat),
    .dataWrStb   (dataWrStb),
    .slvAddrs    (slvAddrs),
    .statusOut   (statusOut),
    .sdaDriveLow (sdaDriveLow)
  );

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    scl = 1'b0; ticks(4);
    sdaM = 1'b1; ticks(4);
    scl = 1'b1; ticks(8);
    sdaM = 1'b0; ticks(8);
  endtask

  task automatic sendBit(input logic b);
    scl = 1'b0; ticks(4);
    sdaM = b; ticks(4);
    scl = 1'b1; ticks(8);
  endtask

  // address byte plus ninth clock; returns ACK seen mid ninth high phase
  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    scl = 1'b0; ticks(4);
    sdaM = 1'b1; ticks(4);
    scl = 1'b1; ticks(4);
    ack = sdaDriveLow;
    ticks(4);
    scl = 1'b0; ticks(4);
  endtask

  task automatic txn(input string tag, input logic [6:0] a, input logic rw,
                     input logic expAck, input logic [7:0] expStat);
    logic ack;
    startCond();
    sendByte({a, rw}, ack);
    chk({tag, " ack"}, {7'd0, ack}, {7'd0, expAck});
    chk({tag, " release R6"}, {7'd0, sdaDriveLow}, 8'd0);
    chk({tag, " status"}, statusOut, expStat);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; ticks(1);
    sig = 1'b0; ticks(1);
  endtask

  task automatic t_reset();
    chk("R1 status", statusOut, 8'h00);
    chk("R1 sda", {7'd0, sdaDriveLow}, 8'd0);
  endtask

  task automatic t_match();
    txn("R3 addr0", 7'h12, 1'b0, 1'b1, 8'h01);
    pulse(dataWrStb);
    chk("R10 clear", statusOut, 8'h00);
    txn("R12 addr1 rw1", 7'h34, 1'b1, 1'b1, 8'h02);
    pulse(dataWrStb);
    txn("R3 addr2", 7'h56, 1'b0, 1'b1, 8'h04);
    txn("R5 sticky or", 7'h12, 1'b0, 1'b1, 8'h05);
    txn("R5 R6 nomatch", 7'h7F, 1'b0, 1'b0, 8'h05);
    chk("R11 reserved", statusOut & 8'hF8, 8'h00);
    pulse(dataWrStb);
    chk("R10 clear2", statusOut, 8'h00);
  endtask

  task automatic t_gcall();
    txn("R4 gcall", 7'h00, 1'b0, 1'b1, 8'h07);
    pulse(softReset);
    chk("R9 clear", statusOut, 8'h00);
    txn("R4 addr0 rw1 not gcall", 7'h00, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_free();
    freeFormat = 1'b1;
    txn("R7 free", 7'h12, 1'b0, 1'b0, 8'h00);
    freeFormat = 1'b0;
    txn("R7 back", 7'h34, 1'b0, 1'b1, 8'h02);
  endtask

  task automatic t_disable();
    enable = 1'b0; ticks(2);
    chk("R8 cleared", statusOut, 8'h00);
    txn("R8 blocked", 7'h12, 1'b0, 1'b0, 8'h00);
    enable = 1'b1; ticks(2);
  endtask

  task automatic t_order();
    logic ack;
    // 0x12 bit-reversed is 0x24: no address matches that reading
    txn("R2 msb first", 7'h24, 1'b0, 1'b0, 8'h00);
    startCond();
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    startCond();
    sendByte({7'h56, 1'b0}, ack);
    chk("R2 restart ack", {7'd0, ack}, 8'd1);
    chk("R2 restart status", statusOut, 8'h04);
    pulse(dataWrStb);
  endtask

  initial begin
    ticks(4);
    rst_n = 1'b1;
    ticks(4);
    t_reset();
    t_match();
    t_gcall();
    t_free();
    t_disable();
    t_order();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule